// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block gives two processor ports a shared set of binary lock flags for token-passing resource allocation. Each port has its own semaphore select, chip enable, output enable, write strobe, flag address and data bus. A port asks for a flag by writing a 0 in data bit 0 and gives it back by writing a 1. Exactly one side owns a taken flag. A request from the side that does not own the flag is held in that side's request latch. When the owner releases the flag, ownership passes to the waiting side on the same clock edge.

A read returns the flag as that side sees it, copied into every data bit. All zeros means this side owns the flag. All ones means it does not. The read value is captured in the first cycle of a read and held until the read ends, so a handover during a long read cannot change the data the processor samples. All logic is synchronous to one clock and has a synchronous active-high reset. Each side's inputs are sampled at every rising edge.

Top module: `dual_sema_unit`

## Requirements
- R1: After reset every flag is free. Both sides' read data is all ones, no error is flagged, and a read of any flag from either side returns all ones.
- R2: A side that writes 0 to a free flag owns it from the next edge. It then reads all zeros (16'h0000) and the other side reads all ones (16'hFFFF).
- R3: While a side owns a flag, a write of 0 or 1 from the other side does not change either side's read value. A 0 from the non-owner is kept as a pending request. A 1 from the non-owner withdraws its pending request.
- R4: When the owner writes 1 and the other side has a pending request, ownership passes to the other side at that edge. The old owner then reads all ones and the new owner reads all zeros.
- R5: When the owner writes 1 and no request is pending, the flag becomes free and both sides read all ones.
- R6: When both sides write 0 to the same free flag in the same cycle, the left side gets the flag and the right side's request stays pending. The right side gets the flag when the left side releases it.
- R7: Only address bits [2:0] select the flag, and only data bit 0 is used on a write. All other address and data bits are ignored.
- R8: Read data is the side's flag view copied into all 16 bits, so it is always 16'h0000 or 16'hFFFF.
- R9: A read is active while the semaphore select is low, chip enable is high, output enable is low and the write strobe is high. The value is captured at the first edge of an active read and stays frozen until the read ends, even if ownership changes in the meantime.
- R10: Semaphore select low together with chip enable low is illegal. Such a cycle changes no flag, and the side's err output is high for one cycle after each illegal cycle. Otherwise err is low.
- R11: With semaphore select high, no flag changes whatever the other inputs do, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low; must be high for semaphore access |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 1 | Left write strobe, low = write |
| l_addr | input | ADDR_W | Left address; bits [2:0] pick the flag |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left captured read data |
| l_err | output | 1 | Left illegal-enable pulse |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 1 | Right write strobe, low = write |
| r_addr | input | ADDR_W | Right address; bits [2:0] pick the flag |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right captured read data |
| r_err | output | 1 | Right illegal-enable pulse |

## Verification
Two events on the same flag can fall in the same cycle: a request from each side, and a release by the owner alongside the other side's request or withdrawal. The bench drives both ports on the same clock edge to provoke these cases. It then reads each side afterwards to judge the left priority and the handover. A handover can also happen while the other side holds a read open. The bench keeps that read active through the release and checks that the captured data stays frozen until output enable is dropped.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic wbit;
    } sema_op_t;

    // Next owner from the current owner and the updated request latches.
    function automatic owner_e owner_next(owner_e cur, logic want_l, logic want_r);
        owner_e nxt;
        case (cur)
            OWN_LEFT:  nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
            OWN_RIGHT: nxt = want_r ? OWN_RIGHT : (want_l ? OWN_LEFT  : OWN_NONE);
            default:   nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
        endcase
        return nxt;
    endfunction

    // Flag as one side sees it: 0 when that side holds the token.
    function automatic logic side_view(owner_e cur, logic is_right);
        return is_right ? (cur != OWN_RIGHT) : (cur != OWN_LEFT);
    endfunction

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode
    import sema_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    parameter int FLAG_AW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sem_n,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               wr_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output sema_op_t           op,
    output logic [FLAG_AW-1:0] sel,
    output logic               err
);
    logic legal;
    logic illegal;
    logic err_q;
    logic unused_bits;

    assign legal   = !sem_n && ce_n;
    assign illegal = !sem_n && !ce_n;

    always_comb begin
        op.wr   = legal && !wr_n;
        op.rd   = legal && !oe_n && wr_n;
        op.wbit = wdata[0];
    end

    assign sel         = addr[FLAG_AW-1:0];
    assign unused_bits = ^{addr[ADDR_W-1:FLAG_AW], wdata[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= illegal;
    end

    assign err = err_q;

    // R10
    no_op_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !op.wr && !op.rd);

endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_l,
    input  logic   bit_l,
    input  logic   wr_r,
    input  logic   bit_r,
    output owner_e owner
);
    logic   req_l_q, req_r_q;
    logic   req_l_n, req_r_n;
    owner_e owner_q, owner_n;

    always_comb begin
        req_l_n = wr_l ? !bit_l : req_l_q;
        req_r_n = wr_r ? !bit_r : req_r_q;
        owner_n = owner_next(owner_q, req_l_n, req_r_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_l_q <= 1'b0;
            req_r_q <= 1'b0;
            owner_q <= OWN_NONE;
        end else begin
            req_l_q <= req_l_n;
            req_r_q <= req_r_n;
            owner_q <= owner_n;
        end
    end

    assign owner = owner_q;

    // R7
    quiet_flag_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_l && !wr_r) |=> $stable(owner_q));

    // R3
    left_keeps_token_chk: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_LEFT && !(wr_l && bit_l)) |=> owner_q == OWN_LEFT);

    // R3
    right_keeps_token_chk: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_RIGHT && !(wr_r && bit_r)) |=> owner_q == OWN_RIGHT);

    // R4
    handover_to_right_chk: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_LEFT && wr_l && bit_l && req_r_q && !(wr_r && bit_r))
        |=> owner_q == OWN_RIGHT);

    // R6
    left_first_chk: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_NONE && wr_l && !bit_l && wr_r && !bit_r)
        |=> owner_q == OWN_LEFT);

endmodule

// File: rtl/sema_read_hold.sv
module sema_read_hold #(
    parameter int DATA_W  = 16,
    parameter int FLAGS   = 8,
    parameter int FLAG_AW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  logic [FLAG_AW-1:0] sel,
    input  logic [FLAGS-1:0]   views,
    output logic [DATA_W-1:0]  rdata
);
    logic              act_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            rdata_q <= '1;
        end else begin
            act_q <= rd;
            if (rd && !act_q) rdata_q <= {DATA_W{views[sel]}};
        end
    end

    assign rdata = rdata_q;

    // R9
    read_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q && rd) |=> $stable(rdata_q));

    // R8
    read_replicated_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata_q == '0) || (rdata_q == '1));

endmodule

// File: rtl/dual_sema_unit.sv
module dual_sema_unit
    import sema_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int FLAGS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_wr_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_err,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_wr_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_err
);
    localparam int FLAG_AW = (FLAGS > 1) ? $clog2(FLAGS) : 1;

    sema_op_t           op_l, op_r;
    logic [FLAG_AW-1:0] sel_l, sel_r;
    logic [FLAGS-1:0]   view_l, view_r;

    sema_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_AW(FLAG_AW)) u_dec_l (
        .clk(clk), .rst(rst), .sem_n(l_sem_n), .ce_n(l_ce_n), .oe_n(l_oe_n),
        .wr_n(l_wr_n), .addr(l_addr), .wdata(l_wdata),
        .op(op_l), .sel(sel_l), .err(l_err)
    );

    sema_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_AW(FLAG_AW)) u_dec_r (
        .clk(clk), .rst(rst), .sem_n(r_sem_n), .ce_n(r_ce_n), .oe_n(r_oe_n),
        .wr_n(r_wr_n), .addr(r_addr), .wdata(r_wdata),
        .op(op_r), .sel(sel_r), .err(r_err)
    );

    for (genvar i = 0; i < FLAGS; i++) begin : g_flag
        logic   hit_l, hit_r;
        owner_e own;

        assign hit_l = op_l.wr && (sel_l == FLAG_AW'(i));
        assign hit_r = op_r.wr && (sel_r == FLAG_AW'(i));

        sema_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .wr_l(hit_l), .bit_l(op_l.wbit),
            .wr_r(hit_r), .bit_r(op_r.wbit),
            .owner(own)
        );

        assign view_l[i] = side_view(own, 1'b0);
        assign view_r[i] = side_view(own, 1'b1);
    end

    sema_read_hold #(.DATA_W(DATA_W), .FLAGS(FLAGS), .FLAG_AW(FLAG_AW)) u_rd_l (
        .clk(clk), .rst(rst), .rd(op_l.rd), .sel(sel_l), .views(view_l), .rdata(l_rdata)
    );

    sema_read_hold #(.DATA_W(DATA_W), .FLAGS(FLAGS), .FLAG_AW(FLAG_AW)) u_rd_r (
        .clk(clk), .rst(rst), .rd(op_r.rd), .sel(sel_r), .views(view_r), .rdata(r_rdata)
    );

    // R2
    never_both_own_chk: assert property (@(posedge clk) disable iff (rst)
        ((~view_l & ~view_r) == '0));

endmodule

// File: tb/dual_sema_unit_test.sv
module dual_sema_unit_test;

    localparam int AW = 14;
    localparam int DW = 16;
    localparam logic [DW-1:0] ONES  = 16'hFFFF;
    localparam logic [DW-1:0] ZEROS = 16'h0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sem_n = 2'b11;
    logic [1:0] ce_n  = 2'b11;
    logic [1:0] oe_n  = 2'b11;
    logic [1:0] wr_n  = 2'b11;
    logic [AW-1:0] addr  [2];
    logic [DW-1:0] wdata [2];
    logic [DW-1:0] rdata [2];
    logic [1:0] err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_sema_unit uut (
        .clk(clk), .rst(rst),
        .l_sem_n(sem_n[0]), .l_ce_n(ce_n[0]), .l_oe_n(oe_n[0]), .l_wr_n(wr_n[0]),
        .l_addr(addr[0]), .l_wdata(wdata[0]), .l_rdata(rdata[0]), .l_err(err[0]),
        .r_sem_n(sem_n[1]), .r_ce_n(ce_n[1]), .r_oe_n(oe_n[1]), .r_wr_n(wr_n[1]),
        .r_addr(addr[1]), .r_wdata(wdata[1]), .r_rdata(rdata[1]), .r_err(err[1])
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_side(int s);
        sem_n[s] = 1'b1; ce_n[s] = 1'b1; oe_n[s] = 1'b1; wr_n[s] = 1'b1;
    endtask

    task automatic sem_write(int s, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        addr[s] = a; wdata[s] = d; sem_n[s] = 1'b0; wr_n[s] = 1'b0;
        @(negedge clk);
        idle_side(s);
    endtask

    task automatic both_write(logic [AW-1:0] a, logic dl, logic dr);
        @(negedge clk);
        addr[0] = a; wdata[0] = {15'd0, dl}; sem_n[0] = 1'b0; wr_n[0] = 1'b0;
        addr[1] = a; wdata[1] = {15'd0, dr}; sem_n[1] = 1'b0; wr_n[1] = 1'b0;
        @(negedge clk);
        idle_side(0); idle_side(1);
    endtask

    task automatic sem_read_chk(int s, logic [AW-1:0] a, logic [DW-1:0] exp, string req);
        @(negedge clk);
        addr[s] = a; sem_n[s] = 1'b0; oe_n[s] = 1'b0;
        @(negedge clk);
        check(req, rdata[s], exp);
        idle_side(s);
    endtask

    task automatic t_reset();
        check("R1 left err",  {15'd0, err[0]}, ZEROS);
        check("R1 right err", {15'd0, err[1]}, ZEROS);
        check("R1 left rdata",  rdata[0], ONES);
        check("R1 right rdata", rdata[1], ONES);
        for (int f = 0; f < 8; f++) begin
            sem_read_chk(0, AW'(f), ONES, "R1 left flag free");
            sem_read_chk(1, AW'(f), ONES, "R1 right flag free");
        end
    endtask

    task automatic t_claim();
        sem_write(0, 14'd2, 16'h0000);
        sem_read_chk(0, 14'd2, ZEROS, "R2 owner reads zeros");
        sem_read_chk(1, 14'd2, ONES,  "R2 other reads ones");
    endtask

    task automatic t_pending_and_handover();
        sem_write(1, 14'd2, 16'h0000);
        sem_read_chk(0, 14'd2, ZEROS, "R3 owner unchanged by other 0");
        sem_read_chk(1, 14'd2, ONES,  "R3 non-owner still ones");
        sem_write(0, 14'd2, 16'h0001);
        sem_read_chk(1, 14'd2, ZEROS, "R4 new owner reads zeros");
        sem_read_chk(0, 14'd2, ONES,  "R4 old owner reads ones");
        sem_write(1, 14'd2, 16'h0001);
        sem_read_chk(0, 14'd2, ONES, "R5 free left");
        sem_read_chk(1, 14'd2, ONES, "R5 free right");
    endtask

    task automatic t_withdraw();
        sem_write(0, 14'd3, 16'h0000);
        sem_write(1, 14'd3, 16'h0000);
        sem_write(1, 14'd3, 16'h0001);
        sem_read_chk(0, 14'd3, ZEROS, "R3 owner unchanged by other 1");
        sem_write(0, 14'd3, 16'h0001);
        sem_read_chk(1, 14'd3, ONES, "R3 withdrawn request not granted");
        sem_read_chk(0, 14'd3, ONES, "R5 flag free after withdraw");
    endtask

    task automatic t_simul();
        both_write(14'd5, 1'b0, 1'b0);
        sem_read_chk(0, 14'd5, ZEROS, "R6 left wins tie");
        sem_read_chk(1, 14'd5, ONES,  "R6 right loses tie");
        sem_write(0, 14'd5, 16'h0001);
        sem_read_chk(1, 14'd5, ZEROS, "R6 right gets pending flag");
        sem_write(1, 14'd5, 16'h0001);
        sem_read_chk(0, 14'd5, ONES, "R5 flag5 free again");
    endtask

    task automatic t_addr_data();
        sem_write(0, 14'h3FF9, 16'hFFFE);
        sem_read_chk(0, 14'h0001, ZEROS, "R7 high addr/data bits ignored");
        sem_read_chk(1, 14'h2A01, ONES,  "R7 other side alias");
        sem_read_chk(0, 14'h3FF8, ONES,  "R7 neighbour flag untouched");
        sem_write(0, 14'h1001, 16'h0001);
        sem_read_chk(0, 14'd1, ONES, "R8 release reads all ones");
    endtask

    task automatic t_hold();
        sem_write(0, 14'd6, 16'h0000);
        sem_write(1, 14'd6, 16'h0000);
        @(negedge clk);
        addr[1] = 14'd6; sem_n[1] = 1'b0; oe_n[1] = 1'b0;
        @(negedge clk);
        check("R9 captured value", rdata[1], ONES);
        sem_write(0, 14'd6, 16'h0001);
        @(negedge clk);
        check("R9 frozen during handover", rdata[1], ONES);
        idle_side(1);
        sem_read_chk(1, 14'd6, ZEROS, "R9 new read sees handover");
        sem_write(1, 14'd6, 16'h0001);
    endtask

    task automatic t_illegal();
        @(negedge clk);
        addr[0] = 14'd7; wdata[0] = 16'h0000; sem_n[0] = 1'b0; ce_n[0] = 1'b0; wr_n[0] = 1'b0;
        @(negedge clk);
        check("R10 err pulse left",     {15'd0, err[0]}, 16'd1);
        check("R10 no err on right",    {15'd0, err[1]}, 16'd0);
        idle_side(0);
        @(negedge clk);
        check("R10 err drops", {15'd0, err[0]}, 16'd0);
        sem_read_chk(0, 14'd7, ONES, "R10 illegal write suppressed");
        sem_read_chk(1, 14'd7, ONES, "R10 flag7 still free");
    endtask

    task automatic t_unselected();
        @(negedge clk);
        addr[1] = 14'd4; wdata[1] = 16'h0000; ce_n[1] = 1'b0; wr_n[1] = 1'b0; sem_n[1] = 1'b1;
        @(negedge clk);
        check("R11 no err without select", {15'd0, err[1]}, 16'd0);
        idle_side(1);
        sem_read_chk(1, 14'd4, ONES, "R11 no flag change without select");
    endtask

    initial begin
        addr[0] = '0; addr[1] = '0; wdata[0] = '0; wdata[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_claim();
        t_pending_and_handover();
        t_withdraw();
        t_simul();
        t_addr_data();
        t_hold();
        t_illegal();
        t_unselected();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule